// File: doc/BRIEF.md
# DDR2 Power-Up Initialisation Sequencer

This block brings a DDR2 device from power-on to normal operation. After a single start pulse it steps through the fixed series of commands the device requires. It opens with two NOPs, the second of which raises the clock-enable line. It then issues a precharge of all banks and writes the three extended mode registers in turn. The mode register is written once with DLL reset and once with the operating settings, and the OCD calibration default and exit writes close the series. Between commands it inserts idle NOP cycles whose counts come from three programmable wait inputs, all measured in controller clocks.

Which mode register is written is chosen by the 2-bit bank address. The address bus carries the register payload. The sequencer sets and clears the DLL-reset bit of the mode-register payload itself. It also writes the OCD field and the DLL-enable bit of the first extended register, so the caller supplies only the operating values. While the series runs, a busy flag tells the surrounding controller to hold off all external accesses. A done flag marks entry to normal mode.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: In reset, and when idle with no start seen, the command output is NOP (code 0), the bank address is 00, the address is zero, and clock-enable, busy and done are all low.
- R2: A start pulse in the idle state begins the series. Busy rises on the first clock after the start pulse is sampled. Without a start pulse the outputs stay as in R1.
- R3: Commands are coded NOP=0, precharge-all=1, mode write=2, extended mode write=3, refresh=4. The non-NOP commands come in this order: precharge-all; extended write with bank 10 and the ext-2 payload; extended write with bank 11; extended write with bank 01 (DLL enable); mode write with bank 00 (DLL reset); precharge-all; refresh; refresh; mode write with bank 00 (operating); extended write with bank 01 (OCD default); extended write with bank 01 (OCD exit). Every command lasts one cycle. NOP cycles carry bank 00 and address zero. Precharge and refresh carry address zero.
- R4: After each command, exactly W NOP cycles follow before the next one. W is the short wait, except in three places: the long wait after the second NOP and after the first precharge, and the lock wait after the DLL-enable write.
- R5: The bank-11 extended write carries an all-zero address whatever the inputs are.
- R6: The mode-register payload is the mode input with address bit 8 forced to 1 in the DLL-reset write and forced to 0 in the operating write.
- R7: Each bank-01 write carries the ext-1 input with bit 0 cleared (DLL enabled). Its OCD field, bits 9:7, is 000 in the DLL-enable write, 111 in the OCD-default write and 000 in the OCD-exit write.
- R8: Clock-enable rises in the cycle of the second NOP, which comes short-wait+1 cycles after the first. It then stays high until reset.
- R9: Done rises short-wait+1 cycles after the final command, in the same cycle busy falls. It stays high with NOP on the command output until reset.
- R10: A start pulse during the series, or after done, changes no output and no timing.
- R11: Busy is high from the first command of the series until done rises, and busy and done are never both high.
- R12: Wait counts of zero give back-to-back commands with no NOP between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| wait_short_i | input | CW | NOP cycles after most commands |
| wait_long_i | input | CW | NOP cycles after the second NOP and the first precharge |
| wait_lock_i | input | CW | NOP cycles after the DLL-enable write |
| mr_i | input | AW | Operating mode-register payload |
| emr1_i | input | AW | Extended register 1 payload |
| emr2_i | input | AW | Extended register 2 payload |
| cmd_o | output | 3 | Command code (see R3) |
| ba_o | output | 2 | Bank address selecting the register |
| addr_o | output | AW | Address bus with the register payload |
| cke_o | output | 1 | Clock-enable level to the device |
| busy_o | output | 1 | Series in progress; hold off external access |
| done_o | output | 1 | Normal mode entered |

## Verification
The bench walks the whole series several times and checks every cycle's command, bank and address against a table. It uses different wait settings, including all-zero waits, so an off-by-one in the wait counter shows up as a shifted command. Payloads are chosen with bit 8, bit 0 and the OCD field already set or already clear, so a sequencer that passed the inputs through unchanged would show the wrong DLL-reset or OCD values. A start pulse injected in the middle of the lock wait, and another after done, would restart or disturb a design that did not ignore them. A reset in the middle of the series must return every output to its idle value.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_LMR  = 3'd2,
    CMD_ELMR = 3'd3,
    CMD_REF  = 3'd4
  } cmd_e;

  // Payload source selection for the address bus
  typedef enum logic [2:0] {
    PL_ZERO    = 3'd0,
    PL_EMR2    = 3'd1,
    PL_EMR1    = 3'd2,
    PL_MR_RST  = 3'd3,
    PL_MR_RUN  = 3'd4,
    PL_OCD_DEF = 3'd5
  } pl_e;

  typedef enum logic [1:0] {
    WT_SHORT = 2'd0,
    WT_LONG  = 2'd1,
    WT_LOCK  = 2'd2
  } wt_e;

  typedef struct packed {
    cmd_e       cmd;
    logic [1:0] ba;
    pl_e        pl;
    wt_e        wt;
    logic       cke_on;
  } step_t;

  localparam int unsigned N_STEPS = 13;

  function automatic step_t mk_step(cmd_e c, logic [1:0] b, pl_e p, wt_e w, logic k);
    step_t s;
    s.cmd    = c;
    s.ba     = b;
    s.pl     = p;
    s.wt     = w;
    s.cke_on = k;
    return s;
  endfunction

endpackage

// File: rtl/ddr2_step_rom.sv
module ddr2_step_rom
  import ddr2_init_pkg::*;
#(
  parameter int unsigned IW = 4
) (
  input  logic [IW-1:0] idx_i,
  output step_t         step_o
);

  always_comb begin
    case (idx_i)
      IW'(0):  step_o = mk_step(CMD_NOP,  2'b00, PL_ZERO,    WT_SHORT, 1'b0);
      IW'(1):  step_o = mk_step(CMD_NOP,  2'b00, PL_ZERO,    WT_LONG,  1'b1);
      IW'(2):  step_o = mk_step(CMD_PREA, 2'b00, PL_ZERO,    WT_LONG,  1'b0);
      IW'(3):  step_o = mk_step(CMD_ELMR, 2'b10, PL_EMR2,    WT_SHORT, 1'b0);
      IW'(4):  step_o = mk_step(CMD_ELMR, 2'b11, PL_ZERO,    WT_SHORT, 1'b0);
      IW'(5):  step_o = mk_step(CMD_ELMR, 2'b01, PL_EMR1,    WT_LOCK,  1'b0);
      IW'(6):  step_o = mk_step(CMD_LMR,  2'b00, PL_MR_RST,  WT_SHORT, 1'b0);
      IW'(7):  step_o = mk_step(CMD_PREA, 2'b00, PL_ZERO,    WT_SHORT, 1'b0);
      IW'(8):  step_o = mk_step(CMD_REF,  2'b00, PL_ZERO,    WT_SHORT, 1'b0);
      IW'(9):  step_o = mk_step(CMD_REF,  2'b00, PL_ZERO,    WT_SHORT, 1'b0);
      IW'(10): step_o = mk_step(CMD_LMR,  2'b00, PL_MR_RUN,  WT_SHORT, 1'b0);
      IW'(11): step_o = mk_step(CMD_ELMR, 2'b01, PL_OCD_DEF, WT_SHORT, 1'b0);
      IW'(12): step_o = mk_step(CMD_ELMR, 2'b01, PL_EMR1,    WT_SHORT, 1'b0);
      default: step_o = mk_step(CMD_NOP,  2'b00, PL_ZERO,    WT_SHORT, 1'b0);
    endcase
  end

endmodule

// File: rtl/ddr2_payload_mux.sv
module ddr2_payload_mux
  import ddr2_init_pkg::*;
#(
  parameter int unsigned AW          = 14,
  parameter int unsigned DLL_RST_BIT = 8,
  parameter int unsigned OCD_LSB     = 7
) (
  input  pl_e           sel_i,
  input  logic [AW-1:0] mr_i,
  input  logic [AW-1:0] emr1_i,
  input  logic [AW-1:0] emr2_i,
  output logic [AW-1:0] addr_o
);

  localparam logic [AW-1:0] DLL_RST_MASK = AW'(1) << DLL_RST_BIT;
  localparam logic [AW-1:0] OCD_MASK     = AW'(7) << OCD_LSB;
  localparam logic [AW-1:0] DLL_DIS_MASK = AW'(1);

  logic [AW-1:0] emr1_base;

  // Extended register 1 with the DLL enabled and OCD field cleared
  assign emr1_base = emr1_i & ~(OCD_MASK | DLL_DIS_MASK);

  always_comb begin
    case (sel_i)
      PL_EMR2:    addr_o = emr2_i;
      PL_EMR1:    addr_o = emr1_base;
      PL_MR_RST:  addr_o = mr_i | DLL_RST_MASK;
      PL_MR_RUN:  addr_o = mr_i & ~DLL_RST_MASK;
      PL_OCD_DEF: addr_o = emr1_base | OCD_MASK;
      default:    addr_o = '0;
    endcase
  end

endmodule

// File: rtl/ddr2_wait_cnt.sv
module ddr2_wait_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned AW          = 14,
  parameter int unsigned CW          = 16,
  parameter int unsigned DLL_RST_BIT = 8,
  parameter int unsigned OCD_LSB     = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [CW-1:0] wait_short_i,
  input  logic [CW-1:0] wait_long_i,
  input  logic [CW-1:0] wait_lock_i,
  input  logic [AW-1:0] mr_i,
  input  logic [AW-1:0] emr1_i,
  input  logic [AW-1:0] emr2_i,
  output logic [2:0]    cmd_o,
  output logic [1:0]    ba_o,
  output logic [AW-1:0] addr_o,
  output logic          cke_o,
  output logic          busy_o,
  output logic          done_o
);

  localparam int unsigned   IW       = $clog2(N_STEPS);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_STEPS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e        state_q;
  logic [IW-1:0] step_q;
  logic [IW-1:0] idx;
  step_t         step;
  logic [AW-1:0] payload;
  logic [CW-1:0] wait_sel;
  logic          timer_zero;
  logic          fire_first;
  logic          fire_next;
  logic          fire;
  logic          finish;

  assign fire_first = (state_q == ST_IDLE) && start_i;
  assign fire_next  = (state_q == ST_RUN) && timer_zero && (step_q != LAST_IDX);
  assign finish     = (state_q == ST_RUN) && timer_zero && (step_q == LAST_IDX);
  assign fire       = fire_first || fire_next;
  assign idx        = fire_first ? '0 : step_q + IW'(1);

  ddr2_step_rom #(.IW(IW)) u_rom (
    .idx_i  (idx),
    .step_o (step)
  );

  ddr2_payload_mux #(
    .AW          (AW),
    .DLL_RST_BIT (DLL_RST_BIT),
    .OCD_LSB     (OCD_LSB)
  ) u_pl (
    .sel_i  (step.pl),
    .mr_i   (mr_i),
    .emr1_i (emr1_i),
    .emr2_i (emr2_i),
    .addr_o (payload)
  );

  always_comb begin
    case (step.wt)
      WT_LONG: wait_sel = wait_long_i;
      WT_LOCK: wait_sel = wait_lock_i;
      default: wait_sel = wait_short_i;
    endcase
  end

  ddr2_wait_cnt #(.CW(CW)) u_wait (
    .clk    (clk),
    .rst    (rst),
    .load_i (fire),
    .val_i  (wait_sel),
    .zero_o (timer_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cmd_o   <= CMD_NOP;
      ba_o    <= 2'b00;
      addr_o  <= '0;
      cke_o   <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      cmd_o  <= CMD_NOP;
      ba_o   <= 2'b00;
      addr_o <= '0;
      if (fire) begin
        state_q <= ST_RUN;
        step_q  <= idx;
        cmd_o   <= step.cmd;
        ba_o    <= step.ba;
        addr_o  <= payload;
        busy_o  <= 1'b1;
        if (step.cke_on) begin
          cke_o <= 1'b1;
        end
      end
      if (finish) begin
        state_q <= ST_DONE;
        busy_o  <= 1'b0;
        done_o  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr2_pwrup_seq_chk.sv
module ddr2_pwrup_seq_chk #(
  parameter int unsigned AW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [2:0]    cmd_o,
  input logic [1:0]    ba_o,
  input logic [AW-1:0] addr_o,
  input logic          cke_o,
  input logic          busy_o,
  input logic          done_o
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !done_o) |-> (cmd_o == 3'd0 && !cke_o)) else $error("idle not quiet"); // R1

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)) else $error("busy without start"); // R2

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd0) |-> (ba_o == 2'b00 && addr_o == '0)) else $error("nop carries data"); // R3

  AST_LMR_BANK: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd2) |-> (ba_o == 2'b00)) else $error("mode write bank"); // R3

  AST_ELMR_BANK: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd3) |-> (ba_o != 2'b00)) else $error("ext write bank"); // R3

  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    cke_o |=> cke_o) else $error("cke dropped"); // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && cmd_o == 3'd0)) else $error("done not held"); // R9

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o)) else $error("busy and done"); // R11

endmodule

bind ddr2_pwrup_seq ddr2_pwrup_seq_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .cmd_o   (cmd_o),
  .ba_o    (ba_o),
  .addr_o  (addr_o),
  .cke_o   (cke_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/test_ddr2_pwrup_seq.sv
module test_ddr2_pwrup_seq;

  localparam int AW = 14;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [CW-1:0] wait_short_i = '0;
  logic [CW-1:0] wait_long_i = '0;
  logic [CW-1:0] wait_lock_i = '0;
  logic [AW-1:0] mr_i = '0;
  logic [AW-1:0] emr1_i = '0;
  logic [AW-1:0] emr2_i = '0;
  logic [2:0]    cmd_o;
  logic [1:0]    ba_o;
  logic [AW-1:0] addr_o;
  logic          cke_o;
  logic          busy_o;
  logic          done_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ddr2_pwrup_seq i_ddr2_pwrup_seq (
    .clk (clk), .rst (rst), .start_i (start_i),
    .wait_short_i (wait_short_i), .wait_long_i (wait_long_i), .wait_lock_i (wait_lock_i),
    .mr_i (mr_i), .emr1_i (emr1_i), .emr2_i (emr2_i),
    .cmd_o (cmd_o), .ba_o (ba_o), .addr_o (addr_o),
    .cke_o (cke_o), .busy_o (busy_o), .done_o (done_o)
  );

  // Step table: {cmd[2:0], ba[1:0], payload kind[2:0], wait kind[1:0], cke rises}
  // payload: 0 zero, 1 ext2, 2 ext1 base, 3 mode+dllrst, 4 mode run, 5 ext1 ocd default
  // wait: 0 short, 1 long, 2 lock
  localparam logic [10:0] STEPS [13] = '{
    {3'd0, 2'b00, 3'd0, 2'd0, 1'b0},
    {3'd0, 2'b00, 3'd0, 2'd1, 1'b1},
    {3'd1, 2'b00, 3'd0, 2'd1, 1'b0},
    {3'd3, 2'b10, 3'd1, 2'd0, 1'b0},
    {3'd3, 2'b11, 3'd0, 2'd0, 1'b0},
    {3'd3, 2'b01, 3'd2, 2'd2, 1'b0},
    {3'd2, 2'b00, 3'd3, 2'd0, 1'b0},
    {3'd1, 2'b00, 3'd0, 2'd0, 1'b0},
    {3'd4, 2'b00, 3'd0, 2'd0, 1'b0},
    {3'd4, 2'b00, 3'd0, 2'd0, 1'b0},
    {3'd2, 2'b00, 3'd4, 2'd0, 1'b0},
    {3'd3, 2'b01, 3'd5, 2'd0, 1'b0},
    {3'd3, 2'b01, 3'd2, 2'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [2:0] kind);
    logic [AW-1:0] base;
    base = emr1_i & ~(14'h0380 | 14'h0001);
    case (kind)
      3'd1:    return emr2_i;
      3'd2:    return base;
      3'd3:    return mr_i | 14'h0100;
      3'd4:    return mr_i & ~14'h0100;
      3'd5:    return base | 14'h0380;
      default: return '0;
    endcase
  endfunction

  task automatic chk_quiet(input string tag);
    chk(cmd_o == 3'd0 && ba_o == 2'b00 && addr_o == '0 && !cke_o && !busy_o && !done_o,
        tag, {cmd_o, ba_o, addr_o, cke_o, busy_o, done_o}, 32'h0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_quiet("R1 reset state");
  endtask

  task automatic run_seq(input int ws, input int wl, input int wk,
                         input logic [AW-1:0] mr, input logic [AW-1:0] e1,
                         input logic [AW-1:0] e2, input bit poke);
    bit cke_exp;
    int w;
    do_reset();
    wait_short_i = CW'(ws);
    wait_long_i = CW'(wl);
    wait_lock_i = CW'(wk);
    mr_i = mr;
    emr1_i = e1;
    emr2_i = e2;
    @(negedge clk);
    chk_quiet("R2 idle before start");
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cke_exp = 1'b0;
    for (int s = 0; s < 13; s++) begin
      logic [10:0] e;
      e = STEPS[s];
      if (e[0]) cke_exp = 1'b1;
      // R3 R5 R6 R7: command, bank and payload of each step
      chk(cmd_o == e[10:8] && ba_o == e[7:6] && addr_o == exp_addr(e[5:3]),
          $sformatf("R3 step %0d cmd/ba/addr", s),
          {cmd_o, ba_o, addr_o}, {e[10:8], e[7:6], exp_addr(e[5:3])});
      chk(cke_o == cke_exp, $sformatf("R8 cke at step %0d", s), cke_o, cke_exp);
      chk(busy_o && !done_o, $sformatf("R11 busy at step %0d", s), {busy_o, done_o}, 2'b10);
      w = (e[2:1] == 2'd1) ? wl : (e[2:1] == 2'd2) ? wk : ws;
      for (int g = 0; g < w; g++) begin
        @(negedge clk);
        if (poke && s == 5) start_i = (g == 0);  // R10 start mid-run
        chk(cmd_o == 3'd0 && ba_o == 2'b00 && addr_o == '0 && cke_o == cke_exp && busy_o,
            $sformatf("R4 gap step %0d cycle %0d", s, g),
            {cmd_o, ba_o, addr_o, cke_o, busy_o}, {3'd0, 2'b00, {AW{1'b0}}, cke_exp, 1'b1});
      end
      start_i = 1'b0;
      @(negedge clk);
    end
    chk(done_o && !busy_o && cke_o && cmd_o == 3'd0, "R9 done after final gap",
        {done_o, busy_o, cke_o, cmd_o}, {1'b1, 1'b0, 1'b1, 3'd0});
    start_i = 1'b1;  // R10 start after done
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(done_o && !busy_o && cke_o && cmd_o == 3'd0 && addr_o == '0, "R10 start after done ignored",
          {done_o, busy_o, cke_o, cmd_o}, {1'b1, 1'b0, 1'b1, 3'd0});
    end
  endtask

  initial begin
    // Vector runs: mode payload with bit 8 clear, ext-1 with bit 0 and OCD set
    run_seq(2, 5, 20, 14'h0632, 14'h0F85, 14'h0080, 1'b1);
    // R12: all waits zero, mode payload with bit 8 already set
    run_seq(0, 0, 0, 14'h0D73, 14'h0044, 14'h1234, 1'b0);
    run_seq(0, 3, 7, 14'h3FFF, 14'h3FFF, 14'h2AAA, 1'b0);
    // R1: reset in the middle of the series
    do_reset();
    wait_short_i = CW'(1);
    wait_long_i = CW'(4);
    wait_lock_i = CW'(9);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (12) @(negedge clk);
    chk(busy_o && cke_o, "R11 busy mid-run", {busy_o, cke_o}, 2'b11);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_quiet("R1 reset mid-run");
    rst = 1'b0;
    // R2: no start, nothing happens
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk_quiet("R2 no start stays idle");
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule